// File: doc/BRIEF.md
# Mode-Toggled Output Oscillation Monitor

This block performs an online self-test of a logic cone built from dual-mode gates. Each gate in the cone computes NAND in one mode and NOR in the other, and one shared control line switches every gate at once. A correct cone is designed to give the same answer in both modes. A stuck-at fault inside the cone makes one of its ordinary functional outputs follow the mode line instead. While testing is enabled, the monitor drives that mode line with a square wave and watches the chosen output bit. It flags a fault whenever the output differs between the two halves of a mode period.

The operand interval is `OP_CYCLES` clocks. The multiplier input `k` sets how many full mode periods fit into one operand interval, so every mode phase lasts about `OP_CYCLES/(2k)` clocks. A phase accumulator produces the edges, so a `k` that does not divide evenly still gives exactly `2k` phases per interval. The observed bit is sampled once, on the last clock of each phase. The NAND-phase sample and the NOR-phase sample that follows it form a pair. A mismatch within a pair raises a one-clock fault pulse and sets a latch that is cleared only by reset. Normal operand traffic serves as the test vectors, provided the operands change only at interval boundaries. A fault sitting directly on the watched output cannot make it toggle, so this method cannot see that fault.

Top module: `modeswing_monitor`

## Requirements
- R1: While `test_en` is low, `mode_ctl` is 0 (NAND mode) and `fault_pulse` and `fault_sticky` are 0 in that same cycle, whatever `obs` does.
- R2: `mode_ctl` = 1 selects NOR mode. After `test_en` rises, `mode_ctl` first goes to 1 after exactly `OP_CYCLES/(2k)` enabled clock edges when `k` divides `OP_CYCLES/2`. Every later phase has that same length.
- R3: For any `k`, the first `OP_CYCLES` enabled edges hold exactly `2k` mode edges. Each phase lasts floor or ceil of `OP_CYCLES/(2k)` edges.
- R4: `k` = 0 behaves as `k` = 1. A `k` above `OP_CYCLES/4` behaves as `OP_CYCLES/4`, so the shortest phase is 2 clocks.
- R5: When `obs` holds the same value in both halves of a mode period, no fault pulse occurs. This includes an `obs` that is constant for a whole run.
- R6: When `obs` follows `mode_ctl`, `fault_pulse` is high for exactly one cycle at the end of every NOR phase, in the cycle where `mode_ctl` has just returned to 0.
- R7: `obs` is sampled only on the last edge of each phase. A change in any other cycle, including the first cycle after a mode switch, has no effect.
- R8: `fault_sticky` rises with the first fault pulse and stays set. It reads 0 while `test_en` is low and reads 1 again as soon as `test_en` returns high.
- R9: Synchronous active-high `rst` clears the fault latch.
- R10: Dropping `test_en` abandons any half-finished pair. The next enable starts afresh with a full NAND phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Enables mode toggling and checking |
| k | input | KW | Mode periods per operand interval |
| obs | input | 1 | Watched functional output of the cone |
| mode_ctl | output | 1 | Shared gate mode: 0 NAND, 1 NOR |
| fault_pulse | output | 1 | One-cycle pulse on a pair mismatch |
| fault_sticky | output | 1 | Fault latch, masked while disabled |

## Verification
The bench injects glitches on `obs` in the cycle right after each mode switch. A design that sampled anywhere other than the phase end would report false faults there.

It uses `k` values that do not divide the interval evenly, as well as zero and out-of-range values. A design with a plain divider or without clamping would show the wrong edge count, or a one-clock phase.

It drops `test_en` in the middle of a NOR phase. A design that kept the stale NAND sample would pulse early after re-enable.

It also toggles enable around a set latch. This catches a latch that was cleared by disable, or one that was not masked while disabled.

// File: rtl/modeswing_pkg.sv
`timescale 1ns/1ps
package modeswing_pkg;

    typedef enum logic {
        GATE_NAND = 1'b0,
        GATE_NOR  = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic       strobe;
        gate_mode_e ending;
    } phase_evt_t;

    function automatic int unsigned clamp_mult(input int unsigned req, input int unsigned top);
        if (req == 0)
            return 1;
        else if (req > top)
            return top;
        else
            return req;
    endfunction

    function automatic gate_mode_e flip_mode(input gate_mode_e m);
        return (m == GATE_NAND) ? GATE_NOR : GATE_NAND;
    endfunction

endpackage

// File: rtl/modeswing_phase_gen.sv
`timescale 1ns/1ps
module modeswing_phase_gen
    import modeswing_pkg::*;
#(
    parameter int OP_CYCLES = 48,
    parameter int KW        = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [KW-1:0] k,
    output gate_mode_e    mode,
    output phase_evt_t    evt
);
    localparam int KMAX  = OP_CYCLES / 4;
    localparam int ACC_W = $clog2(2 * OP_CYCLES) + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic             wrap;
    int unsigned      k_eff;

    always_comb begin
        k_eff = clamp_mult(32'(k), KMAX);
        step  = ACC_W'(2 * k_eff);
        sum   = acc + step;
        wrap  = (sum >= ACC_W'(OP_CYCLES));
        evt.strobe = run && wrap;
        evt.ending = mode;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc  <= '0;
            mode <= GATE_NAND;
        end else if (wrap) begin
            acc  <= sum - ACC_W'(OP_CYCLES);
            mode <= flip_mode(mode);
        end else begin
            acc  <= sum;
        end
    end

endmodule

// File: rtl/modeswing_pair_cmp.sv
`timescale 1ns/1ps
module modeswing_pair_cmp
    import modeswing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  phase_evt_t evt,
    input  logic       obs,
    output logic       mism_now,
    output logic       pulse
);
    logic held;
    logic have;

    always_comb begin
        mism_now = run && evt.strobe && (evt.ending == GATE_NOR) && have && (obs != held);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            held  <= 1'b0;
            have  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= mism_now;
            if (evt.strobe) begin
                if (evt.ending == GATE_NAND) begin
                    held <= obs;
                    have <= 1'b1;
                end else begin
                    have <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/modeswing_fault_hold.sv
`timescale 1ns/1ps
module modeswing_fault_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic latched
);
    always_ff @(posedge clk) begin
        if (rst)
            latched <= 1'b0;
        else if (set)
            latched <= 1'b1;
    end
endmodule

// File: rtl/modeswing_monitor.sv
`timescale 1ns/1ps
module modeswing_monitor
    import modeswing_pkg::*;
#(
    parameter int OP_CYCLES = 48,
    parameter int KW        = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test_en,
    input  logic [KW-1:0] k,
    input  logic          obs,
    output logic          mode_ctl,
    output logic          fault_pulse,
    output logic          fault_sticky
);
    gate_mode_e mode;
    phase_evt_t evt;
    logic       mism_now;
    logic       pulse_q;
    logic       latch_q;

    modeswing_phase_gen #(.OP_CYCLES(OP_CYCLES), .KW(KW)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .run  (test_en),
        .k    (k),
        .mode (mode),
        .evt  (evt)
    );

    modeswing_pair_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .run      (test_en),
        .evt      (evt),
        .obs      (obs),
        .mism_now (mism_now),
        .pulse    (pulse_q)
    );

    modeswing_fault_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .set     (mism_now),
        .latched (latch_q)
    );

    always_comb begin
        mode_ctl     = test_en && (mode == GATE_NOR);
        fault_pulse  = test_en && pulse_q;
        fault_sticky = test_en && latch_q;
    end

endmodule

// File: rtl/modeswing_monitor_chk.sv
`timescale 1ns/1ps
module modeswing_monitor_chk (
    input logic clk,
    input logic rst,
    input logic test_en,
    input logic mode_ctl,
    input logic fault_pulse,
    input logic fault_sticky
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> (!mode_ctl && !fault_pulse && !fault_sticky));

    assert_phase_min_R4: assert property (@(posedge clk) disable iff (rst)
        (test_en && $past(test_en) && (mode_ctl != $past(mode_ctl))) |=> (!test_en || $stable(mode_ctl)));

    assert_pulse_at_nand_R6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (!mode_ctl && $past(mode_ctl)));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    assert_pulse_sets_latch_R8: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> fault_sticky);

    assert_latch_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (test_en && $past(test_en) && $past(fault_sticky)) |-> fault_sticky);
endmodule

bind modeswing_monitor modeswing_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .test_en      (test_en),
    .mode_ctl     (mode_ctl),
    .fault_pulse  (fault_pulse),
    .fault_sticky (fault_sticky)
);

// File: tb/modeswing_monitor_test.sv
`timescale 1ns/1ps
module modeswing_monitor_test;
    localparam int OP = 48;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          test_en = 1'b0;
    logic [KW-1:0] k = 8'd1;
    logic          val = 1'b0;
    logic          inj = 1'b0;
    logic          glitch_en = 1'b0;
    logic          glitch = 1'b0;
    logic          prev_mode = 1'b0;
    logic          change_val = 1'b0;
    logic          mode_ctl, fault_pulse, fault_sticky;
    logic          obs;
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;

    assign obs = val ^ (inj & mode_ctl) ^ (glitch_en & glitch);

    modeswing_monitor #(.OP_CYCLES(OP), .KW(KW)) uut (
        .clk(clk), .rst(rst), .test_en(test_en), .k(k), .obs(obs),
        .mode_ctl(mode_ctl), .fault_pulse(fault_pulse), .fault_sticky(fault_sticky)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        glitch    <= (mode_ctl != prev_mode);
        prev_mode <= mode_ctl;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_run(input int kv);
        test_en = 1'b0;
        tick();
        k = KW'(kv);
        test_en = 1'b1;
    endtask

    task automatic run_window(input int edges, output int trans, output int pulses,
                              output int first_edge, output int minlen, output int maxlen,
                              output int first_pulse);
        int last;
        logic pm;
        trans = 0; pulses = 0; first_edge = -1; minlen = 1000; maxlen = 0;
        first_pulse = -1; last = 0; pm = 1'b0;
        for (int n = 1; n <= edges; n++) begin
            tick();
            if (mode_ctl != pm) begin
                trans = trans + 1;
                if (first_edge < 0) first_edge = n;
                if (n - last < minlen) minlen = n - last;
                if (n - last > maxlen) maxlen = n - last;
                last = n;
                pm = mode_ctl;
            end
            if (fault_pulse) begin
                pulses = pulses + 1;
                if (first_pulse < 0) first_pulse = n;
            end
            if (change_val && (n % OP == 0)) val = 1'($urandom);
        end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        int tr, pu, fe, mn, mx, fp, seed;
        int ks[7];
        seed = $urandom(32'd4242);
        ks = '{1, 2, 3, 4, 6, 8, 12};

        // R1: reset and disabled state
        do_reset();
        chk("R1 mode idle", int'(mode_ctl), 0);
        chk("R1 pulse idle", int'(fault_pulse), 0);
        chk("R1 sticky idle", int'(fault_sticky), 0);
        inj = 1'b1;
        tr = 0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (mode_ctl || fault_pulse || fault_sticky) tr = tr + 1;
        end
        chk("R1 quiet while disabled", tr, 0);
        inj = 1'b0;

        // R2, R5: k=2 healthy
        val = 1'b1;
        start_run(2);
        run_window(OP, tr, pu, fe, mn, mx, fp);
        chk("R2 first edge k=2", fe, 12);
        chk("R2 min phase k=2", mn, 12);
        chk("R2 max phase k=2", mx, 12);
        chk("R2 edges k=2", tr, 4);
        chk("R5 no pulse healthy", pu, 0);

        // R4: clamping
        start_run(0);
        run_window(OP, tr, pu, fe, mn, mx, fp);
        chk("R4 k=0 first edge", fe, 24);
        start_run(200);
        run_window(OP, tr, pu, fe, mn, mx, fp);
        chk("R4 k=200 first edge", fe, 2);
        chk("R4 k=200 min phase", mn, 2);
        chk("R4 k=200 edges", tr, 24);

        // R3: uneven multiplier
        start_run(5);
        run_window(2 * OP, tr, pu, fe, mn, mx, fp);
        chk("R3 k=5 edges", tr, 20);
        chk("R3 k=5 min phase", mn, 4);
        chk("R3 k=5 max phase", mx, 5);

        // R7: glitches right after each mode switch are ignored
        glitch_en = 1'b1;
        start_run(4);
        run_window(OP, tr, pu, fe, mn, mx, fp);
        chk("R7 glitch ignored", pu, 0);
        chk("R7 edges k=4", tr, 8);
        glitch_en = 1'b0;
        chk("R7 sticky clear", int'(fault_sticky), 0);

        // R6: output follows mode
        inj = 1'b1;
        change_val = 1'b1;
        start_run(3);
        run_window(2 * OP, tr, pu, fe, mn, mx, fp);
        chk("R6 pulse count k=3", pu, 6);
        chk("R6 first pulse k=3", fp, 16);
        chk("R8 sticky set", int'(fault_sticky), 1);

        // R8: latch holds, masked while disabled
        inj = 1'b0;
        run_window(OP, tr, pu, fe, mn, mx, fp);
        chk("R8 no new pulses", pu, 0);
        chk("R8 sticky holds", int'(fault_sticky), 1);
        test_en = 1'b0;
        #1;
        chk("R8 sticky masked", int'(fault_sticky), 0);
        chk("R1 mode forced nand", int'(mode_ctl), 0);
        tick();
        test_en = 1'b1;
        #1;
        chk("R8 sticky returns", int'(fault_sticky), 1);

        // R9: reset clears latch
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 sticky cleared", int'(fault_sticky), 0);

        // R10: abort mid NOR phase
        inj = 1'b1;
        start_run(2);
        run_window(18, tr, pu, fe, mn, mx, fp);
        chk("R10 in nor phase", int'(mode_ctl), 1);
        start_run(2);
        run_window(30, tr, pu, fe, mn, mx, fp);
        chk("R10 fresh first edge", fe, 12);
        chk("R10 fresh first pulse", fp, 24);

        // R5, R6: random mix
        for (int it = 0; it < 8; it++) begin
            int kv, lp;
            kv = ks[$urandom % 7];
            inj = 1'($urandom);
            val = 1'($urandom);
            do_reset();
            start_run(kv);
            run_window(3 * OP, tr, pu, fe, mn, mx, fp);
            lp = OP / (2 * kv);
            chk(inj ? "R6 random pulses" : "R5 random pulses", pu, inj ? (3 * OP) / (2 * lp) : 0);
            chk("R8 random sticky", int'(fault_sticky), int'(inj));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule